// File: doc/BRIEF.md
# External Hop and FSK Input Controller

This block interprets a single TTL-level auxiliary input on a waveform generator. A mode bit decides what the input is for. In edge mode, transitions on the input pick the active waveform bank (wave hop), pick one of two frequency words (FSK), or fire a counted-burst trigger. In reference mode, the input is passed on as an external reference clock or output gate, and every edge action is suppressed.

The input is asynchronous. It goes through a synchronizer chain and then an edge detector. A sense-invert bit swaps which physical edge counts as the rising one. The block also works out the effective waveform bank. It does this by weighing the register bank field against the output mode, the RAM-size field and the bank chosen by hop edges.

Top module: `aux_hop_ctrl`

## Requirements
- R1: After reset, `hop_sel_o` = 0 (RAM 0), `fsk_sel_o` = 0 (frequency 1), and `rise_evt_o`, `fall_evt_o`, `burst_o` and `ref_o` are 0.
- R2: An input transition that is driven between clock edges produces a one-cycle event strobe, registered at the third rising clock edge after the change. With no sensed transition, no strobe is raised. A rise strobe and a fall strobe are never high together.
- R3: When `out_mode_i` = 1 (hop), a sensed rising edge sets `hop_sel_o` to 0 and a sensed falling edge sets it to 1, on the same cycle as the strobe.
- R4: When `out_mode_i` = 2 (FSK), a sensed rising edge sets `fsk_sel_o` to 0 (frequency 1) and a sensed falling edge sets it to 1 (frequency 2).
- R5: With `sense_inv_i` = 1, a physical rising edge is sensed as falling and a physical falling edge is sensed as rising. This applies to the strobes, hop, FSK and burst. Toggling `sense_inv_i` alone creates no event.
- R6: When `out_mode_i` = 3 (burst), `burst_o` pulses for one cycle on a sensed rising edge only.
- R7: With `ext_ref_i` = 1, no strobes or burst pulses occur and the selections hold. `ref_o` follows the synchronized input, without inversion, with the same latency as the strobes. `ref_o` is 0 when `ext_ref_i` = 0.
- R8: When `ram_size_i` = 0 (smallest size), `eff_bank_o` = 0 whatever the other inputs are.
- R9: With `ram_size_i` nonzero, `eff_bank_o` is as follows. It equals `bank_reg_i` in mode 0 (continuous). It equals `hop_sel_o`, zero-extended, in mode 1. It is 0 in every other mode (2 to 7).
- R10: Edges seen in a mode leave the other mode's selection unchanged. For example, FSK edges do not alter `hop_sel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| aux_i | input | 1 | Asynchronous auxiliary input |
| ext_ref_i | input | 1 | 1 = reference/gate use, 0 = edge actions |
| sense_inv_i | input | 1 | Swap sensed edge polarity |
| out_mode_i | input | 3 | 0 continuous, 1 hop, 2 FSK, 3 burst, others none |
| ram_size_i | input | 2 | RAM-size field, 0 = smallest |
| bank_reg_i | input | 2 | Register bank field |
| rise_evt_o | output | 1 | Sensed rising-edge strobe |
| fall_evt_o | output | 1 | Sensed falling-edge strobe |
| burst_o | output | 1 | Burst trigger strobe |
| hop_sel_o | output | 1 | Hop selection: 0 RAM 0, 1 RAM 1 |
| fsk_sel_o | output | 1 | FSK selection: 0 freq 1, 1 freq 2 |
| ref_o | output | 1 | Synchronized reference/gate |
| eff_bank_o | output | 2 | Resolved waveform bank |

## Verification
The hardest case to reach is flipping the sense-invert bit while the input is steady. A naive design would report that as an edge. The stimulus drives the input low, waits out the synchronizer, and toggles only the invert bit. It then confirms that no strobe appears and that the hop selection is unchanged. Only after that does it send real transitions, so it can show they are swapped. Burst edges under inversion and edges in reference mode are handled the same way: the scoreboard expects a strobe only on the cycle the requirement names, and it expects silence on every other cycle.

// File: rtl/aux_hop_pkg.sv
package aux_hop_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    OM_CONT  = 3'd0,
    OM_HOP   = 3'd1,
    OM_FSK   = 3'd2,
    OM_BURST = 3'd3
  } out_mode_e;
endpackage

// File: rtl/aux_sync.sv
module aux_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/aux_edge_det.sv
module aux_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic inv_i,
  input  logic en_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;
  logic raw_rise, raw_fall;

  // history holds the raw level so toggling inv_i cannot fake an edge
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;

  assign raw_rise = lvl_i & ~prev_q;
  assign raw_fall = ~lvl_i & prev_q;
  assign rise_o   = en_i & (inv_i ? raw_fall : raw_rise);
  assign fall_o   = en_i & (inv_i ? raw_rise : raw_fall);
endmodule

// File: rtl/aux_bank_resolve.sv
module aux_bank_resolve
  import aux_hop_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned SIZE_W = 2
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [BANK_W-1:0] bank_reg_i,
  input  logic              hop_sel_i,
  output logic [BANK_W-1:0] bank_o
);
  always_comb begin
    bank_o = '0;
    if (size_i != '0) begin
      unique case (mode_i)
        OM_CONT: bank_o = bank_reg_i;
        OM_HOP:  bank_o = {{(BANK_W-1){1'b0}}, hop_sel_i};
        default: bank_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/aux_hop_ctrl.sv
module aux_hop_ctrl
  import aux_hop_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BANK_W      = 2,
  parameter int unsigned SIZE_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              aux_i,
  input  logic              ext_ref_i,
  input  logic              sense_inv_i,
  input  logic [MODE_W-1:0] out_mode_i,
  input  logic [SIZE_W-1:0] ram_size_i,
  input  logic [BANK_W-1:0] bank_reg_i,
  output logic              rise_evt_o,
  output logic              fall_evt_o,
  output logic              burst_o,
  output logic              hop_sel_o,
  output logic              fsk_sel_o,
  output logic              ref_o,
  output logic [BANK_W-1:0] eff_bank_o
);
  logic aux_s;
  logic rise, fall;
  logic is_hop, is_fsk, is_burst;

  assign is_hop   = (out_mode_i == OM_HOP);
  assign is_fsk   = (out_mode_i == OM_FSK);
  assign is_burst = (out_mode_i == OM_BURST);

  aux_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (aux_i),
    .q_o    (aux_s)
  );

  aux_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (aux_s),
    .inv_i  (sense_inv_i),
    .en_i   (~ext_ref_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_evt_o <= 1'b0;
      fall_evt_o <= 1'b0;
      burst_o    <= 1'b0;
      hop_sel_o  <= 1'b0;
      fsk_sel_o  <= 1'b0;
      ref_o      <= 1'b0;
    end else begin
      rise_evt_o <= rise;
      fall_evt_o <= fall;
      burst_o    <= rise & is_burst;
      ref_o      <= ext_ref_i & aux_s;
      if (is_hop) begin
        if (rise)      hop_sel_o <= 1'b0;
        else if (fall) hop_sel_o <= 1'b1;
      end
      if (is_fsk) begin
        if (rise)      fsk_sel_o <= 1'b0;
        else if (fall) fsk_sel_o <= 1'b1;
      end
    end
  end

  aux_bank_resolve #(.BANK_W(BANK_W), .SIZE_W(SIZE_W)) u_bank (
    .mode_i     (out_mode_i),
    .size_i     (ram_size_i),
    .bank_reg_i (bank_reg_i),
    .hop_sel_i  (hop_sel_o),
    .bank_o     (eff_bank_o)
  );
endmodule

// File: rtl/aux_hop_chk.sv
module aux_hop_chk
  import aux_hop_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned SIZE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ext_ref_i,
  input logic [MODE_W-1:0] out_mode_i,
  input logic [SIZE_W-1:0] ram_size_i,
  input logic              rise_evt_o,
  input logic              fall_evt_o,
  input logic              burst_o,
  input logic              hop_sel_o,
  input logic              fsk_sel_o,
  input logic [BANK_W-1:0] eff_bank_o
);
  a_r2_evt_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_evt_o, fall_evt_o}));

  a_r6_burst_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_o |-> rise_evt_o);

  a_r7_ref_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_ref_i |=> (!rise_evt_o && !fall_evt_o && !burst_o));

  a_r3_hop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_evt_o || fall_evt_o) |-> $stable(hop_sel_o));

  a_r4_fsk_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_evt_o || fall_evt_o) |-> $stable(fsk_sel_o));

  a_r3_hop_rise_ram0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_evt_o && $past(out_mode_i) == OM_HOP) |-> !hop_sel_o);

  a_r4_fsk_fall_f2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_evt_o && $past(out_mode_i) == OM_FSK) |-> fsk_sel_o);

  a_r8_small_bank0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_size_i == '0) |-> (eff_bank_o == '0));
endmodule

bind aux_hop_ctrl aux_hop_chk #(.BANK_W(BANK_W), .SIZE_W(SIZE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ext_ref_i  (ext_ref_i),
  .out_mode_i (out_mode_i),
  .ram_size_i (ram_size_i),
  .rise_evt_o (rise_evt_o),
  .fall_evt_o (fall_evt_o),
  .burst_o    (burst_o),
  .hop_sel_o  (hop_sel_o),
  .fsk_sel_o  (fsk_sel_o),
  .eff_bank_o (eff_bank_o)
);

// File: tb/tb_aux_hop_ctrl.sv
`timescale 1ns/1ps
module tb_aux_hop_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       aux = 1'b0;
  logic       ext = 1'b0;
  logic       inv = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [1:0] size = 2'd3;
  logic [1:0] breg = 2'd2;
  logic       rise_evt, fall_evt, burst, hop_sel, fsk_sel, ref_v;
  logic [1:0] eff_bank;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  bit m_prev = 0, m_hop = 0, m_fsk = 0;

  typedef struct {
    int       at;
    bit       r, f, b, hop, fsk, rf;
    logic [1:0] bank;
    string    tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aux_hop_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .aux_i(aux), .ext_ref_i(ext),
    .sense_inv_i(inv), .out_mode_i(mode), .ram_size_i(size),
    .bank_reg_i(breg), .rise_evt_o(rise_evt), .fall_evt_o(fall_evt),
    .burst_o(burst), .hop_sel_o(hop_sel), .fsk_sel_o(fsk_sel),
    .ref_o(ref_v), .eff_bank_o(eff_bank)
  );

  function automatic logic [1:0] exp_bank(bit hop);
    if (size == 2'd0) return 2'd0;
    if (mode == 3'd0) return breg;
    if (mode == 3'd1) return {1'b0, hop};
    return 2'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h @cyc %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic cfg(bit e, bit i, logic [2:0] m);
    @(negedge clk);
    ext = e; inv = i; mode = m;
    repeat (3) @(negedge clk);
  endtask

  task automatic drive_aux(bit lvl, string tag);
    bit rr, rf, sr, sf;
    item_t it;
    @(negedge clk);
    aux = lvl;
    rr = lvl & !m_prev;
    rf = !lvl & m_prev;
    m_prev = lvl;
    sr = ext ? 1'b0 : (inv ? rf : rr);
    sf = ext ? 1'b0 : (inv ? rr : rf);
    if (mode == 3'd1) begin if (sr) m_hop = 0; else if (sf) m_hop = 1; end
    if (mode == 3'd2) begin if (sr) m_fsk = 0; else if (sf) m_fsk = 1; end
    it.at = cyc + 3; it.r = sr; it.f = sf; it.b = sr && (mode == 3'd3);
    it.hop = m_hop; it.fsk = m_fsk; it.rf = ext ? lvl : 1'b0;
    it.bank = exp_bank(m_hop); it.tag = tag;
    q.push_back(it);
    repeat (6) @(negedge clk);
  endtask

  // monitor: compare scheduled items, demand silence otherwise
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() != 0 && q[0].at == cyc) begin
        item_t it;
        it = q.pop_front();
        chk({it.tag, " rise"}, rise_evt, it.r);
        chk({it.tag, " fall"}, fall_evt, it.f);
        chk({it.tag, " burst"}, burst, it.b);
        chk({it.tag, " hop"}, hop_sel, it.hop);
        chk({it.tag, " fsk"}, fsk_sel, it.fsk);
        chk({it.tag, " ref"}, ref_v, it.rf);
        chk({it.tag, " bank"}, eff_bank, it.bank);
      end else begin
        chk("R2 no strobe", {rise_evt, fall_evt, burst}, 3'b000);
      end
    end
  end

  task automatic bank_case(logic [2:0] m, logic [1:0] s, logic [1:0] b, string tag);
    @(negedge clk);
    mode = m; size = s; breg = b;
    #1;
    chk(tag, eff_bank, exp_bank(hop_sel));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 hop", hop_sel, 0);
    chk("R1 fsk", fsk_sel, 0);
    chk("R1 strobes", {rise_evt, fall_evt, burst, ref_v}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hop after release", hop_sel, 0);
    chk("R1 bank cont", eff_bank, 2'd2);

    cfg(0, 0, 3'd1);
    drive_aux(1, "R3 rise->ram0");
    drive_aux(0, "R3 fall->ram1");
    drive_aux(1, "R3 rise->ram0 again");
    drive_aux(0, "R3 fall->ram1 again");

    cfg(0, 1, 3'd1);
    chk("R5 inv toggle no change", hop_sel, 1);
    drive_aux(1, "R5 inv phys rise->fall");
    drive_aux(0, "R5 inv phys fall->rise");

    cfg(0, 0, 3'd2);
    drive_aux(1, "R4 rise->f1");
    drive_aux(0, "R4 fall->f2");
    chk("R10 hop held in fsk", hop_sel, 0);
    drive_aux(1, "R4 rise->f1 again");
    drive_aux(0, "R4 fall->f2 again");

    cfg(0, 0, 3'd3);
    drive_aux(1, "R6 rise burst");
    drive_aux(0, "R6 fall no burst");
    cfg(0, 1, 3'd3);
    drive_aux(1, "R6 inv phys rise no burst");
    drive_aux(0, "R6 inv phys fall burst");
    chk("R10 fsk held in burst", fsk_sel, 1);

    cfg(1, 1, 3'd1);
    drive_aux(1, "R7 ref high");
    drive_aux(0, "R7 ref low");
    cfg(1, 0, 3'd2);
    drive_aux(1, "R7 ref high fsk");
    chk("R7 fsk held", fsk_sel, 1);
    drive_aux(0, "R7 ref low fsk");

    cfg(0, 0, 3'd1);
    bank_case(3'd0, 2'd0, 2'd3, "R8 size0 cont");
    bank_case(3'd1, 2'd0, 2'd3, "R8 size0 hop");
    bank_case(3'd0, 2'd1, 2'd3, "R9 cont uses reg");
    bank_case(3'd0, 2'd2, 2'd1, "R9 cont uses reg 1");
    bank_case(3'd1, 2'd3, 2'd3, "R9 hop uses sel");
    bank_case(3'd2, 2'd3, 2'd3, "R9 fsk forces 0");
    bank_case(3'd5, 2'd3, 2'd3, "R9 other forces 0");
    chk("R9 hop sel state", hop_sel, m_hop);

    repeat (4) @(negedge clk);
    chk("R2 queue drained", q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule